// File: doc/BRIEF.md
# Atomic Conditional-Store Access Checker

This block decides whether an atomic compare-and-store may proceed at an address that has already been translated. A request carries the translation outcome (success, or a fault code), the page read and write grants, a cache attribute, a control word holding one 2-bit policy field per cacheable class, and a flag that says whether a data cache is present. One cycle after the request strobe, the block presents either a pass indication or an exception cause, with the request address echoed as the faulting address.

The checks are ranked. A translation fault is reported first, exactly as it arrived. A missing read or write grant comes next. The cache-policy check comes last. When no data cache is built, every access is treated as cache-bypass whatever attribute the page carries.

Top module: `amo_access_chk`

## Requirements
- R1: Each request strobe (`req_vld`=1) produces exactly one result strobe (`res_vld`=1) on the next clock edge. `res_vld` is 0 in any cycle that does not follow a strobe, and it is 0 in the cycle after reset.
- R2: A nonzero `xlat_fault` sets `res_pass`=0 and `res_cause` equal to `xlat_fault`. This takes precedence over every other check.
- R3: With no translation fault, if either `perm_rd` or `perm_wr` is 0, the result is `res_pass`=0 with `res_cause`=CAUSE_ST_PROHIB (parameter, default 29).
- R4: Attribute encoding on `cache_attr`: 0 = bypass, 1 = write-through, 2 = write-back, 3 = isolate, 4 to 7 = other. The policy field is taken from `amo_ctl[1:0]` for bypass, `amo_ctl[3:2]` for write-through and `amo_ctl[5:4]` for write-back.
- R5: With translation and permissions good, a selected policy field of 0 gives `res_pass`=0 with `res_cause`=CAUSE_LS_ERR (parameter, default 3). A nonzero field gives `res_pass`=1.
- R6: The isolate attribute always gives `res_pass`=0 with CAUSE_LS_ERR, whatever `amo_ctl` holds.
- R7: An "other" attribute (4 to 7) passes, and `amo_ctl` has no effect on it.
- R8: When `has_dcache`=0, the checker uses `amo_ctl[1:0]` regardless of `cache_attr`. Isolate and "other" are also treated as bypass in this case.
- R9: `res_vaddr` equals the `vaddr` of the request. When `res_pass`=1, `res_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| vaddr | input | AW | Address under check |
| xlat_fault | input | CW | Translation outcome: 0 means success, otherwise a cause code |
| perm_rd | input | 1 | Page grants read |
| perm_wr | input | 1 | Page grants write |
| cache_attr | input | 3 | Cache attribute code (R4) |
| amo_ctl | input | 6 | Three 2-bit atomic policy fields |
| has_dcache | input | 1 | A data cache is configured |
| res_vld | output | 1 | Result strobe |
| res_pass | output | 1 | Atomic may proceed |
| res_cause | output | CW | Exception cause; 0 on pass |
| res_vaddr | output | AW | Faulting address (the request address) |

## Verification
The bench sends random requests in which faults, permission combinations, attributes, control words and the cache flag are all mixed. This exercises every precedence pairing. Directed cases are aimed at specific decisions:
- Each attribute is paired with a control word that zeroes only one field. This shows whether the right field is being selected.
- Isolate is tried with a control word of all ones, and "other" with a control word of zero. These show that the policy check is bypassed for those attributes.
- The attribute is varied while `has_dcache`=0. This shows that the cache flag forces bypass.
- Requests are separated by idle gaps. This confirms that only one result is produced per strobe.

// File: rtl/amo_chk_pkg.sv
package amo_chk_pkg;
   typedef enum logic [2:0] {
      ATTR_BYPASS = 3'd0,
      ATTR_WTHRU  = 3'd1,
      ATTR_WBACK  = 3'd2,
      ATTR_ISOL   = 3'd3,
      ATTR_OTHER  = 3'd4
   } cache_attr_e;

   typedef enum logic [1:0] {
      V_PASS  = 2'd0,
      V_XLAT  = 2'd1,
      V_PERM  = 2'd2,
      V_POL   = 2'd3
   } verdict_e;
endpackage

// File: rtl/amo_policy_sel.sv
module amo_policy_sel
   import amo_chk_pkg::*;
#(
   parameter int FW = 2,
   parameter int NF = 3
) (
   input  logic [2:0]       attr,
   input  logic [FW*NF-1:0] ctl,
   input  logic             has_dcache,
   output logic             pol_fault
);
   localparam int IW = $clog2(NF);
   logic [FW-1:0] fld [NF];
   logic [2:0]    eff;

   for (genvar g = 0; g < NF; g++) begin : g_fld
      assign fld[g] = ctl[g*FW +: FW];
   end

   always_comb begin
      eff = has_dcache ? attr : 3'(ATTR_BYPASS);
      pol_fault = 1'b0;
      if (eff == 3'(ATTR_ISOL))
         pol_fault = 1'b1;
      else if (eff < 3'(NF))
         pol_fault = (fld[IW'(eff)] == '0);
   end
endmodule

// File: rtl/amo_verdict.sv
module amo_verdict
   import amo_chk_pkg::*;
#(
   parameter int CW = 6,
   parameter int CAUSE_ST_PROHIB = 29,
   parameter int CAUSE_LS_ERR = 3
) (
   input  logic [CW-1:0] xlat_fault,
   input  logic          perm_rd,
   input  logic          perm_wr,
   input  logic          pol_fault,
   output logic          pass,
   output logic [CW-1:0] cause
);
   verdict_e v;
   always_comb begin
      if (xlat_fault != '0)            v = V_XLAT;
      else if (!(perm_rd && perm_wr))  v = V_PERM;
      else if (pol_fault)              v = V_POL;
      else                             v = V_PASS;
      pass = (v == V_PASS);
      unique case (v)
         V_XLAT:  cause = xlat_fault;
         V_PERM:  cause = CW'(CAUSE_ST_PROHIB);
         V_POL:   cause = CW'(CAUSE_LS_ERR);
         default: cause = '0;
      endcase
   end
endmodule

// File: rtl/amo_access_chk.sv
module amo_access_chk
   import amo_chk_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 6,
   parameter int CAUSE_ST_PROHIB = 29,
   parameter int CAUSE_LS_ERR = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_vld,
   input  logic [AW-1:0] vaddr,
   input  logic [CW-1:0] xlat_fault,
   input  logic          perm_rd,
   input  logic          perm_wr,
   input  logic [2:0]    cache_attr,
   input  logic [5:0]    amo_ctl,
   input  logic          has_dcache,
   output logic          res_vld,
   output logic          res_pass,
   output logic [CW-1:0] res_cause,
   output logic [AW-1:0] res_vaddr
);
   localparam int FW = 2;
   localparam int NF = 3;

   initial begin
      assert (CW >= 1 && CAUSE_ST_PROHIB > 0 && CAUSE_ST_PROHIB < (1 << CW))
         else $error("CAUSE_ST_PROHIB does not fit CW");
      assert (CAUSE_LS_ERR > 0 && CAUSE_LS_ERR < (1 << CW))
         else $error("CAUSE_LS_ERR does not fit CW");
      assert (AW >= 1) else $error("AW must be positive");
   end

   logic          pol_fault;
   logic          pass_c;
   logic [CW-1:0] cause_c;

   amo_policy_sel #(.FW(FW), .NF(NF)) u_pol (
      .attr(cache_attr), .ctl(amo_ctl), .has_dcache(has_dcache),
      .pol_fault(pol_fault)
   );

   amo_verdict #(.CW(CW), .CAUSE_ST_PROHIB(CAUSE_ST_PROHIB),
                 .CAUSE_LS_ERR(CAUSE_LS_ERR)) u_vrd (
      .xlat_fault(xlat_fault), .perm_rd(perm_rd), .perm_wr(perm_wr),
      .pol_fault(pol_fault), .pass(pass_c), .cause(cause_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld   <= 1'b0;
         res_pass  <= 1'b0;
         res_cause <= '0;
         res_vaddr <= '0;
      end else begin
         res_vld <= req_vld;
         if (req_vld) begin
            res_pass  <= pass_c;
            res_cause <= cause_c;
            res_vaddr <= vaddr;
         end
      end
   end
endmodule

// File: rtl/amo_access_chk_sva.sv
module amo_access_chk_sva #(
   parameter int AW = 32,
   parameter int CW = 6,
   parameter int CAUSE_ST_PROHIB = 29,
   parameter int CAUSE_LS_ERR = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_vld,
   input logic [AW-1:0] vaddr,
   input logic [CW-1:0] xlat_fault,
   input logic          perm_rd,
   input logic          perm_wr,
   input logic [2:0]    cache_attr,
   input logic          has_dcache,
   input logic          res_vld,
   input logic          res_pass,
   input logic [CW-1:0] res_cause
);
   // R1
   result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> res_vld);
   // R1
   no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !res_vld);
   // R2
   xlat_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && xlat_fault != '0) |=> (!res_pass && res_cause == $past(xlat_fault)));
   // R3
   perm_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && xlat_fault == '0 && !(perm_rd && perm_wr))
      |=> (!res_pass && res_cause == CW'(CAUSE_ST_PROHIB)));
   // R6
   isolate_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && xlat_fault == '0 && perm_rd && perm_wr && has_dcache && cache_attr == 3'd3)
      |=> (!res_pass && res_cause == CW'(CAUSE_LS_ERR)));
   // R7
   other_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && xlat_fault == '0 && perm_rd && perm_wr && has_dcache && cache_attr[2])
      |=> res_pass);
   // R9
   pass_zero_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_pass) |-> res_cause == '0);
   // R9
   vaddr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> res_vaddr_q == $past(vaddr));
   logic [AW-1:0] res_vaddr_q;
   assign res_vaddr_q = amo_access_chk.res_vaddr;
endmodule

bind amo_access_chk amo_access_chk_sva #(.AW(AW), .CW(CW),
   .CAUSE_ST_PROHIB(CAUSE_ST_PROHIB), .CAUSE_LS_ERR(CAUSE_LS_ERR)) u_sva (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .vaddr(vaddr),
   .xlat_fault(xlat_fault), .perm_rd(perm_rd), .perm_wr(perm_wr),
   .cache_attr(cache_attr), .has_dcache(has_dcache), .res_vld(res_vld),
   .res_pass(res_pass), .res_cause(res_cause)
);

// File: tb/sim_amo_access_chk.sv
`timescale 1ns/1ps
module sim_amo_access_chk;
   localparam int AW = 32;
   localparam int CW = 6;
   localparam int STP = 29;
   localparam int LSE = 3;

   logic clk = 0, rst_n = 0, req_vld = 0;
   logic [AW-1:0] vaddr = '0;
   logic [CW-1:0] xlat_fault = '0;
   logic perm_rd = 0, perm_wr = 0, has_dcache = 0;
   logic [2:0] cache_attr = '0;
   logic [5:0] amo_ctl = '0;
   logic res_vld, res_pass;
   logic [CW-1:0] res_cause;
   logic [AW-1:0] res_vaddr;
   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   amo_access_chk #(.AW(AW), .CW(CW)) u0 (.*);

   function automatic logic [CW:0] model(input logic [CW-1:0] f, input logic r, input logic w,
                                         input logic [2:0] a, input logic [5:0] c, input logic d);
      logic [2:0] e;
      e = d ? a : 3'd0;
      if (f != 0) return {1'b0, f};
      if (!(r && w)) return {1'b0, CW'(STP)};
      if (e == 3'd3) return {1'b0, CW'(LSE)};
      if (e < 3 && c[e*2 +: 2] == 2'b00) return {1'b0, CW'(LSE)};
      return {1'b1, {CW{1'b0}}};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input string req, input logic [AW-1:0] a, input logic [CW-1:0] f,
                      input logic r, input logic w, input logic [2:0] at,
                      input logic [5:0] c, input logic d);
      logic [CW:0] e;
      @(negedge clk);
      req_vld = 1; vaddr = a; xlat_fault = f; perm_rd = r; perm_wr = w;
      cache_attr = at; amo_ctl = c; has_dcache = d;
      e = model(f, r, w, at, c, d);
      @(negedge clk);
      req_vld = 0;
      check({req, " vld"}, 64'(res_vld), 64'd1);
      check({req, " pass"}, 64'(res_pass), 64'(e[CW]));
      check({req, " cause"}, 64'(res_cause), 64'(e[CW-1:0]));
      check({req, " R9 vaddr"}, 64'(res_vaddr), 64'(a));
   endtask

   initial begin : watchdog
      #(5 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1 reset vld", 64'(res_vld), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1 idle vld", 64'(res_vld), 64'd0);
      // R2 fault wins over everything
      run("R2", 32'hdead_0000, 6'd26, 0, 0, 3'd3, 6'h00, 1);
      // R3 permission
      run("R3 ro", 32'h1000, 0, 1, 0, 3'd0, 6'h3f, 1);
      run("R3 wo", 32'h1004, 0, 0, 1, 3'd7, 6'h3f, 1);
      // R4 R5 field selection
      run("R4 R5 byp0", 32'h2000, 0, 1, 1, 3'd0, 6'b111100, 1);
      run("R4 R5 byp1", 32'h2004, 0, 1, 1, 3'd0, 6'b000001, 1);
      run("R4 R5 wt0",  32'h2008, 0, 1, 1, 3'd1, 6'b110011, 1);
      run("R4 R5 wt1",  32'h200c, 0, 1, 1, 3'd1, 6'b001000, 1);
      run("R4 R5 wb0",  32'h2010, 0, 1, 1, 3'd2, 6'b001111, 1);
      run("R4 R5 wb1",  32'h2014, 0, 1, 1, 3'd2, 6'b100000, 1);
      // R6 isolate
      run("R6", 32'h3000, 0, 1, 1, 3'd3, 6'h3f, 1);
      // R7 other
      run("R7 a4", 32'h3004, 0, 1, 1, 3'd4, 6'h00, 1);
      run("R7 a7", 32'h3008, 0, 1, 1, 3'd7, 6'h00, 1);
      // R8 no data cache
      run("R8 iso", 32'h4000, 0, 1, 1, 3'd3, 6'b000010, 0);
      run("R8 wb",  32'h4004, 0, 1, 1, 3'd2, 6'b111100, 0);
      run("R8 oth", 32'h4008, 0, 1, 1, 3'd5, 6'b111100, 0);
      @(negedge clk);
      check("R1 gap vld", 64'(res_vld), 64'd0);
      for (int i = 0; i < 400; i++) begin
         logic [CW-1:0] f;
         f = ($urandom % 4 == 0) ? CW'($urandom) : '0;
         run("R2 R3 R5 rand", $urandom, f, 1'($urandom), ($urandom % 5) != 0,
             3'($urandom), 6'($urandom), 1'($urandom));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule